// File: doc/BRIEF.md
# Serial Word-Boundary Aligner and Deserializer

This block takes a recovered serial bit stream, one bit per serial clock, and rebuilds parallel words from it. Every frame on the line is 25 bits long: a guard bit that is always 0, 22 payload bits sent least significant first, and a pair of trailer bits that both carry the complement of the final payload bit. No sync word exists. The receiver finds the frame edge purely from this guard and trailer structure. It slides its frame window one bit at a time until the structure repeats at a fixed offset.

Once aligned, the block writes each payload word to a parallel output and raises a one-clock strobe with it. It keeps checking the guard and trailer bits of every later frame. A single bad frame while aligned drops the lock and produces a one-clock error pulse, which the link uses as its fault indication. The search then starts again, so alignment comes back by itself after a break in the signal. Clock recovery from the line is outside this block.

Top module: `frame_aligner_rx`

## Requirements
- R1: A frame passes its check only when its guard bit (first bit) is 0 and both trailer bits (bits 24 and 25 of the frame) are equal to each other and to the inverse of the last payload bit (bit 23 of the frame).
- R2: The block declares lock after 4 frames in a row pass the check at the same bit offset. The frame that completes lock is not presented. `locked_o` rises one serial clock after the last bit of the fourth passing frame.
- R3: The first payload bit after the guard bit appears on `word_o[0]` and the 22nd appears on `word_o[21]`.
- R4: While locked, each passing frame raises `word_vld_o` for exactly one clock, one clock after its last trailer bit, with the word on `word_o` in the same cycle. `word_vld_o` is never high while `locked_o` is low.
- R5: Whenever `word_vld_o` is low, `word_o` keeps its previous value. This includes the whole time the block is unlocked.
- R6: A frame that fails its check while the block is locked drops `locked_o`, raises `bnd_err_o` for exactly one clock, and is not presented.
- R7: A frame whose guard bit is 1 fails the check (a case of R1).
- R8: A frame whose two trailer bits differ fails the check, even when the first trailer bit is correct (a case of R1).
- R9: While unlocked, each failing candidate frame moves the next candidate one bit later, so lock returns without outside help after misaligned data or an interruption.
- R10: After reset `word_o` is 0 and `word_vld_o`, `locked_o` and `bnd_err_o` are low.
- R11: `bnd_err_o` never pulses while the block is unlocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Serial bit clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ser_i | input | 1 | Serial data bit, one per clock |
| word_o | output | 22 | Last recovered payload word |
| word_vld_o | output | 1 | One-clock strobe marking a new word |
| locked_o | output | 1 | Frame alignment held |
| bnd_err_o | output | 1 | One-clock pulse on a failed check while locked |

## Verification
The bench targets each way a frame can fail: a guard bit set, both trailer bits equal to the last payload bit, trailer bits that differ only in the second position, and a long run of ones that stands for a lost signal. A receiver that checked only the first trailer bit would stay locked on the unequal-trailer frame and present it. A receiver that never slid its window would not lock again after the run of ones. Lock timing is checked at the frame where lock occurs, so an off-by-one in the match counter or in presenting the locking frame shows up as a wrong word count. Words with a single set bit at either end expose a reversed bit order. Because the outputs must hold through the bad frame, a receiver that updated `word_o` without a strobe would show a changed word.

// File: rtl/fa_pkg.sv
package fa_pkg;

    typedef enum logic {
        ST_HUNT = 1'b0,
        ST_LOCK = 1'b1
    } align_e;

    // Trailer rule: both trailer bits equal and opposite to the last payload bit
    function automatic logic trailer_ok(input logic last_bit,
                                        input logic tr0,
                                        input logic tr1);
        return (tr0 == tr1) && (tr0 != last_bit);
    endfunction

endpackage

// File: rtl/fa_window.sv
module fa_window #(
    parameter int DATA_W = 22
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              ser_i,
    output logic              frame_ok_o,
    output logic [DATA_W-1:0] word_o
);
    localparam int FRAME_W  = DATA_W + 3;
    localparam int LAST_IDX = DATA_W;
    localparam int TR0_IDX  = DATA_W + 1;
    localparam int TR1_IDX  = DATA_W + 2;

    typedef struct packed {
        logic [FRAME_W-1:0] sr;
    } win_t;

    win_t win_d, win_q;

    // Oldest bit sits at index 0 (the guard position of a candidate frame)
    always_comb begin
        win_d    = win_q;
        win_d.sr = {ser_i, win_q.sr[FRAME_W-1:1]};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) win_q <= '0;
        else         win_q <= win_d;
    end

    assign frame_ok_o = ~win_q.sr[0] &
                        fa_pkg::trailer_ok(win_q.sr[LAST_IDX],
                                           win_q.sr[TR0_IDX],
                                           win_q.sr[TR1_IDX]);

    for (genvar g = 0; g < DATA_W; g++) begin : g_pay
        assign word_o[g] = win_q.sr[g+1];
    end
endmodule

// File: rtl/fa_ctrl.sv
module fa_ctrl #(
    parameter int FRAME_W     = 25,
    parameter int LOCK_FRAMES = 4
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic frame_ok_i,
    output logic take_o,
    output logic err_o,
    output logic locked_o
);
    localparam int CNT_W = $clog2(FRAME_W + 1);
    localparam int HIT_W = (LOCK_FRAMES > 1) ? $clog2(LOCK_FRAMES) : 1;
    localparam logic [CNT_W-1:0] CNT_SLIP = CNT_W'(FRAME_W);
    localparam logic [CNT_W-1:0] CNT_NEXT = CNT_W'(FRAME_W - 1);
    localparam logic [HIT_W-1:0] HIT_LAST = HIT_W'(LOCK_FRAMES - 1);

    typedef struct packed {
        fa_pkg::align_e   st;
        logic [HIT_W-1:0] hits;
        logic [CNT_W-1:0] cnt;
        logic             err;
    } ctrl_t;

    ctrl_t ctl_d, ctl_q;
    logic  at_edge;

    assign at_edge = (ctl_q.cnt == '0);

    always_comb begin
        ctl_d     = ctl_q;
        ctl_d.err = 1'b0;
        if (at_edge) begin
            if (frame_ok_i) begin
                ctl_d.cnt = CNT_NEXT;
                if (ctl_q.st == fa_pkg::ST_HUNT) begin
                    if (ctl_q.hits == HIT_LAST) begin
                        ctl_d.st   = fa_pkg::ST_LOCK;
                        ctl_d.hits = '0;
                    end else begin
                        ctl_d.hits = ctl_q.hits + 1'b1;
                    end
                end
            end else begin
                // one extra clock before the next candidate: slide by one bit
                ctl_d.cnt  = CNT_SLIP;
                ctl_d.hits = '0;
                if (ctl_q.st == fa_pkg::ST_LOCK) begin
                    ctl_d.st  = fa_pkg::ST_HUNT;
                    ctl_d.err = 1'b1;
                end
            end
        end else begin
            ctl_d.cnt = ctl_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ctl_q.st   <= fa_pkg::ST_HUNT;
            ctl_q.hits <= '0;
            ctl_q.cnt  <= CNT_SLIP;
            ctl_q.err  <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign take_o   = at_edge & frame_ok_i & (ctl_q.st == fa_pkg::ST_LOCK);
    assign err_o    = ctl_q.err;
    assign locked_o = (ctl_q.st == fa_pkg::ST_LOCK);
endmodule

// File: rtl/fa_outreg.sv
module fa_outreg #(
    parameter int DATA_W = 22
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              load_i,
    input  logic [DATA_W-1:0] word_i,
    output logic [DATA_W-1:0] word_o,
    output logic              vld_o
);
    typedef struct packed {
        logic [DATA_W-1:0] word;
        logic              vld;
    } out_t;

    out_t out_d, out_q;

    always_comb begin
        out_d     = out_q;
        out_d.vld = load_i;
        if (load_i) out_d.word = word_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) out_q <= '0;
        else         out_q <= out_d;
    end

    assign word_o = out_q.word;
    assign vld_o  = out_q.vld;
endmodule

// File: rtl/frame_aligner_rx.sv
module frame_aligner_rx #(
    parameter int DATA_W      = 22,
    parameter int LOCK_FRAMES = 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              ser_i,
    output logic [DATA_W-1:0] word_o,
    output logic              word_vld_o,
    output logic              locked_o,
    output logic              bnd_err_o
);
    localparam int FRAME_W = DATA_W + 3;

    logic              frame_ok;
    logic              take;
    logic [DATA_W-1:0] cand_word;

    fa_window #(.DATA_W(DATA_W)) win_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .ser_i      (ser_i),
        .frame_ok_o (frame_ok),
        .word_o     (cand_word)
    );

    fa_ctrl #(.FRAME_W(FRAME_W), .LOCK_FRAMES(LOCK_FRAMES)) ctrl_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .frame_ok_i (frame_ok),
        .take_o     (take),
        .err_o      (bnd_err_o),
        .locked_o   (locked_o)
    );

    fa_outreg #(.DATA_W(DATA_W)) outr_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .load_i (take),
        .word_i (cand_word),
        .word_o (word_o),
        .vld_o  (word_vld_o)
    );
endmodule

// File: rtl/frame_aligner_rx_chk.sv
module frame_aligner_rx_chk #(
    parameter int DATA_W = 22
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic [DATA_W-1:0] word_o,
    input logic              word_vld_o,
    input logic              locked_o,
    input logic              bnd_err_o
);
    // R4
    vld_needs_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        word_vld_o |-> locked_o);

    // R5
    word_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !word_vld_o |-> $stable(word_o));

    // R6
    err_one_clk_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bnd_err_o |=> !bnd_err_o);

    // R6
    err_drops_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bnd_err_o |-> (!locked_o && $past(locked_o)));

    // R11
    no_err_hunting_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$past(locked_o) |-> !bnd_err_o);

    // R2
    lock_frame_hidden_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(locked_o) |-> !word_vld_o);
endmodule

bind frame_aligner_rx frame_aligner_rx_chk #(.DATA_W(DATA_W)) chk_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .word_o     (word_o),
    .word_vld_o (word_vld_o),
    .locked_o   (locked_o),
    .bnd_err_o  (bnd_err_o)
);

// File: tb/frame_aligner_rx_tb_top.sv
`timescale 1ns/1ps
module frame_aligner_rx_tb_top;
    localparam int DW = 22;
    localparam logic [DW-1:0] ALT = 22'h155555;
    localparam int NVEC = 10;
    // bit 22: expected to be presented; bits 21:0: payload
    localparam logic [DW:0] VEC [NVEC] = '{
        {1'b0, 22'h2AAAAA}, {1'b0, 22'h155555}, {1'b0, 22'h3FFFFF}, {1'b0, 22'h000000},
        {1'b1, 22'h000001}, {1'b1, 22'h200000}, {1'b1, 22'h123456}, {1'b1, 22'h3ABCDE},
        {1'b1, 22'h0F0F0F}, {1'b1, 22'h30C30C}
    };

    logic          clk_i = 1'b0;
    logic          rst_ni = 1'b0;
    logic          ser_i = 1'b0;
    logic [DW-1:0] word_o;
    logic          word_vld_o, locked_o, bnd_err_o;

    int checks = 0, errors = 0;
    int err_cnt = 0, vld_cnt = 0, rec_n = 0;
    bit cap_en = 1'b0, err_prev = 1'b0;
    logic [DW-1:0] rec [16];

    always #5 clk_i = ~clk_i;

    frame_aligner_rx dut_i (
        .clk_i(clk_i), .rst_ni(rst_ni), .ser_i(ser_i), .word_o(word_o),
        .word_vld_o(word_vld_o), .locked_o(locked_o), .bnd_err_o(bnd_err_o)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    always @(negedge clk_i) begin
        if (rst_ni) begin
            if (bnd_err_o) err_cnt++;
            if (bnd_err_o && err_prev) check(1'b0, "R6 error wider than one clock", 2, 1);
            if (word_vld_o && !locked_o) check(1'b0, "R4 strobe while unlocked", 1, 0);
            if (word_vld_o) begin
                vld_cnt++;
                if (cap_en && rec_n < 16) begin
                    rec[rec_n] = word_o;
                    rec_n++;
                end
            end
            err_prev = bnd_err_o;
        end
    end

    initial begin
        repeat (100000) @(posedge clk_i);
        check(1'b0, "watchdog expired", 0, 1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    task automatic send_bit(input logic b);
        ser_i = b;
        @(negedge clk_i);
    endtask

    // kind: 0 good, 1 guard set, 2 trailers equal last bit, 3 trailers differ
    task automatic send_frame(input logic [DW-1:0] w, input int kind);
        logic tr;
        tr = ~w[DW-1];
        send_bit(kind == 1);
        for (int i = 0; i < DW; i++) send_bit(w[i]);
        send_bit(kind == 2 ? w[DW-1] : tr);
        send_bit((kind == 2 || kind == 3) ? w[DW-1] : tr);
    endtask

    task automatic relock(input string req, input int e_exp);
        for (int i = 0; i < 45; i++) send_frame(ALT, 0);
        check(locked_o == 1'b1, {req, " relock"}, locked_o, 1);
        check(word_o == ALT, {req, " word after relock"}, word_o, ALT);
        check(err_cnt == e_exp, "R11 no error while hunting", err_cnt, e_exp);
    endtask

    task automatic bad_frame(input int kind, input string req, input int e_exp);
        int v0;
        v0 = vld_cnt;
        send_frame(22'h0F0F0F, kind);
        send_frame(ALT, 0);
        check(err_cnt == e_exp, {req, " error pulse"}, err_cnt, e_exp);
        check(locked_o == 1'b0, {req, " lock dropped"}, locked_o, 0);
        check(vld_cnt - v0 == 1, "R6 bad frame not presented", vld_cnt - v0, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk_i);
        // R10 reset state
        check(word_o == '0, "R10 word", word_o, 0);
        check(word_vld_o == 1'b0, "R10 strobe", word_vld_o, 0);
        check(locked_o == 1'b0, "R10 locked", locked_o, 0);
        check(bnd_err_o == 1'b0, "R10 error", bnd_err_o, 0);
        rst_ni = 1'b1;
        cap_en = 1'b1;

        // table walk: R1 R2 R3 R4
        for (int i = 0; i < NVEC; i++) begin
            if (i == 4) check(locked_o == 1'b0, "R2 not locked before fourth check", locked_o, 0);
            send_frame(VEC[i][DW-1:0], 0);
            if (i == 4) begin
                check(locked_o == 1'b1, "R2 locked after four frames", locked_o, 1);
                check(vld_cnt == 0, "R2 locking frame hidden", vld_cnt, 0);
            end
        end

        // R6 with trailers equal to last bit; R5 hold of last word
        bad_frame(2, "R6", 1);
        check(word_o == VEC[NVEC-1][DW-1:0], "R5 word held", word_o, VEC[NVEC-1][DW-1:0]);
        cap_en = 1'b0;
        begin
            int n_exp;
            n_exp = 0;
            for (int i = 0; i < NVEC; i++) if (VEC[i][DW]) n_exp++;
            check(rec_n == n_exp, "R2 presented word count", rec_n, n_exp);
            for (int i = 0, k = 0; i < NVEC; i++) begin
                if (VEC[i][DW] && k < rec_n) begin
                    check(rec[k] == VEC[i][DW-1:0], "R3 R1 word content", rec[k], VEC[i][DW-1:0]);
                    k++;
                end
            end
        end
        relock("R9", 1);

        bad_frame(1, "R7", 2);
        relock("R7", 2);

        bad_frame(3, "R8", 3);
        relock("R8", 3);

        // interruption: long run of ones, R9
        for (int i = 0; i < 60; i++) send_bit(1'b1);
        check(err_cnt == 4, "R9 single error on interruption", err_cnt, 4);
        check(locked_o == 1'b0, "R9 unlocked during interruption", locked_o, 0);
        check(word_o == ALT, "R5 word held during interruption", word_o, ALT);
        relock("R9", 4);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule